// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Condition Flags

This block is the combinational arithmetic and logic stage of an 8-bit accumulator datapath. From two operands, the incoming flag byte and a 4-bit operation code, it produces the 8-bit result and the new flag byte in the same cycle. It also produces a write-enable that tells the register file whether the result should be stored.

The flag byte follows the layout S=bit 7, Z=bit 6, Y=bit 5, H=bit 4, X=bit 3, PV=bit 2, N=bit 1 and C=bit 0. The bits are generated per operation: carry and borrow, half-carry between bit 3 and bit 4, a PV bit that means signed overflow for arithmetic and even parity for logic operations, and two bits (5 and 3) that copy data bits. Decimal adjust reads the incoming N, H and C flags, so the block can correct the result of the preceding BCD add or subtract.

Top module: `alu8_core`

## Requirements
- R1: Op codes are ADD=0, ADC=1, SUB=2, SBC=3, CP=4, AND=5, OR=6, XOR=7, INC=8, DEC=9, CPL=10, NEG=11 and DAA=12. ADD gives a+b and ADC gives a+b+C_in. For both, H is the carry out of bit 3, PV is signed overflow, C is the carry out of bit 7 and N=0.
- R2: SUB gives a-b and SBC gives a-b-C_in. For both, H is the borrow out of bit 3, PV is signed overflow, C is the borrow out of bit 7 and N=1.
- R3: CP sets the flags of SUB, except that flag bits 5 and 3 copy bits 5 and 3 of b; wr_o is 0.
- R4: AND, OR and XOR give the bitwise result with C=0 and N=0, and PV=1 when the result has an even number of ones. H is 1 for AND and 0 for OR and XOR.
- R5: INC gives a+1 and DEC gives a-1. H is the carry or borrow of bit 3, PV=1 exactly when a is 0x7F (INC) or 0x80 (DEC), N is 0 for INC and 1 for DEC, and C keeps C_in.
- R6: CPL gives ~a and sets H=1 and N=1. S, Z, PV and C keep their incoming values, and bits 5 and 3 copy the result.
- R7: NEG gives 0-a with subtraction flags: N=1, C=1 when a is not 0, PV=1 when a is 0x80, and H=1 when the low nibble of a is not 0.
- R8: DAA adds 0x06 when the low nibble of a is above 9 or H_in is set, and adds 0x60 when a is above 0x99 or C_in is set. With N_in=1 these amounts are subtracted instead. C becomes 1 when the 0x60 amount applies and keeps C_in otherwise. H becomes (low nibble > 9) when N_in=0, and (H_in and low nibble < 6) when N_in=1. N keeps N_in and PV is even parity.
- R9: For every op except CPL and the unused codes, S is result bit 7 and Z=1 when the result is 0. Except for CP, bits 5 and 3 copy result bits 5 and 3.
- R10: For INC, DEC, CPL, NEG and DAA, b_i has no effect on any output.
- R11: Op codes 13 to 15 give res_o=a, flags_o=flags_i and wr_o=0.
- R12: wr_o is 1 for all op codes from 0 to 12 except CP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| a_i | input | 8 | Accumulator operand |
| b_i | input | 8 | Second operand |
| flags_i | input | 8 | Incoming flag byte |
| res_o | output | 8 | Result |
| flags_o | output | 8 | New flag byte |
| wr_o | output | 1 | Result should be written back |

## Verification
The bench drives the signed-overflow edges 0x7F+1, 0x80-1 and NEG 0x80. A design that confused carry with overflow, or ignored the operand signs, would miss PV on these. It drives nibble borrows such as 0x10-1 and 0x0F+1, which catch a half-carry taken from the wrong bit or with the wrong polarity for subtraction. DAA runs with every combination of N, H and C over both in-range and out-of-range values, so a wrong direction or a wrong C and H rule shows up in the result. Compares run with b chosen so that its bits 5 and 3 differ from the result's, exposing a design that copies the result into those bits.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW = 8;
  localparam int NW = DW / 2;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3,
    OP_CP  = 4'd4,  OP_AND = 4'd5,  OP_OR  = 4'd6,  OP_XOR = 4'd7,
    OP_INC = 4'd8,  OP_DEC = 4'd9,  OP_CPL = 4'd10, OP_NEG = 4'd11,
    OP_DAA = 4'd12
  } alu_op_e;

  localparam int F_C  = 0;
  localparam int F_N  = 1;
  localparam int F_PV = 2;
  localparam int F_X  = 3;
  localparam int F_H  = 4;
  localparam int F_Y  = 5;
  localparam int F_Z  = 6;
  localparam int F_S  = 7;

  function automatic logic even_par(input logic [DW-1:0] v);
    return ~^v;
  endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int DW = 8,
  localparam int NW = DW / 2
) (
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] y_i,
  input  logic          sub_i,
  input  logic          ci_i,   // carry (add) or borrow (sub) in
  output logic [DW-1:0] sum_o,
  output logic          half_o,
  output logic          carry_o,
  output logic          ovf_o
);
  logic [DW-1:0] ye;
  logic          cie;
  logic [NW:0]   lo, hi;

  always_comb begin
    ye  = sub_i ? ~y_i : y_i;
    cie = sub_i ? ~ci_i : ci_i;
    lo  = {1'b0, x_i[NW-1:0]} + {1'b0, ye[NW-1:0]} + {{NW{1'b0}}, cie};
    hi  = {1'b0, x_i[DW-1:NW]} + {1'b0, ye[DW-1:NW]} + {{NW{1'b0}}, lo[NW]};
    sum_o   = {hi[NW-1:0], lo[NW-1:0]};
    half_o  = lo[NW] ^ sub_i;
    carry_o = hi[NW] ^ sub_i;
    ovf_o   = (x_i[DW-1] == ye[DW-1]) && (sum_o[DW-1] != x_i[DW-1]);
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic #(
  parameter int DW = 8
) (
  input  logic [1:0]    kind_i,  // 0 and, 1 or, 2 xor
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] res_o
);
  always_comb begin
    unique case (kind_i)
      2'd0:    res_o = a_i & b_i;
      2'd1:    res_o = a_i | b_i;
      default: res_o = a_i ^ b_i;
    endcase
  end
endmodule

// File: rtl/alu8_daa.sv
module alu8_daa #(
  parameter int DW = 8,
  localparam int NW = DW / 2
) (
  input  logic [DW-1:0] a_i,
  input  logic          c_i,
  input  logic          h_i,
  input  logic          n_i,
  output logic [DW-1:0] res_o,
  output logic          c_o,
  output logic          h_o
);
  logic          lo_big, fix_lo, fix_hi;
  logic [DW-1:0] corr;

  always_comb begin
    lo_big = a_i[NW-1:0] > NW'(9);
    fix_lo = h_i | lo_big;
    fix_hi = c_i | (a_i > DW'(8'h99));
    corr   = {(fix_hi ? NW'(6) : NW'(0)), (fix_lo ? NW'(6) : NW'(0))};
    res_o  = n_i ? (a_i - corr) : (a_i + corr);
    c_o    = fix_hi;
    h_o    = n_i ? (h_i & (a_i[NW-1:0] < NW'(6))) : lo_big;
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic [3:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic [DW-1:0] flags_i,
  output logic [DW-1:0] res_o,
  output logic [DW-1:0] flags_o,
  output logic          wr_o
);
  logic [DW-1:0] as_x, as_y, as_sum, lg_res, da_res;
  logic          as_sub, as_ci, as_half, as_carry, as_ovf, da_c, da_h;
  logic [1:0]    lg_kind;
  logic [DW-1:0] f;
  logic [DW-1:0] r;

  // adder operand selection
  always_comb begin
    as_x = a_i; as_y = b_i; as_sub = 1'b0; as_ci = 1'b0;
    case (op_i)
      OP_ADC: as_ci = flags_i[F_C];
      OP_SUB, OP_CP: as_sub = 1'b1;
      OP_SBC: begin as_sub = 1'b1; as_ci = flags_i[F_C]; end
      OP_INC: as_y = DW'(1);
      OP_DEC: begin as_y = DW'(1); as_sub = 1'b1; end
      OP_NEG: begin as_x = '0; as_y = a_i; as_sub = 1'b1; end
      default: ;
    endcase
  end

  alu8_addsub #(.DW(DW)) u_addsub (
    .x_i(as_x), .y_i(as_y), .sub_i(as_sub), .ci_i(as_ci),
    .sum_o(as_sum), .half_o(as_half), .carry_o(as_carry), .ovf_o(as_ovf)
  );

  assign lg_kind = (op_i == OP_AND) ? 2'd0 : (op_i == OP_OR) ? 2'd1 : 2'd2;

  alu8_logic #(.DW(DW)) u_logic (
    .kind_i(lg_kind), .a_i(a_i), .b_i(b_i), .res_o(lg_res)
  );

  alu8_daa #(.DW(DW)) u_daa (
    .a_i(a_i), .c_i(flags_i[F_C]), .h_i(flags_i[F_H]), .n_i(flags_i[F_N]),
    .res_o(da_res), .c_o(da_c), .h_o(da_h)
  );

  always_comb begin
    r    = a_i;
    f    = flags_i;
    wr_o = 1'b1;
    case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CP, OP_INC, OP_DEC, OP_NEG: begin
        r       = as_sum;
        f[F_H]  = as_half;
        f[F_PV] = as_ovf;
        f[F_N]  = as_sub;
        f[F_C]  = (op_i == OP_INC || op_i == OP_DEC) ? flags_i[F_C] : as_carry;
        wr_o    = (op_i != OP_CP);
      end
      OP_AND, OP_OR, OP_XOR: begin
        r       = lg_res;
        f[F_H]  = (op_i == OP_AND);
        f[F_PV] = even_par(lg_res);
        f[F_N]  = 1'b0;
        f[F_C]  = 1'b0;
      end
      OP_CPL: begin
        r      = ~a_i;
        f[F_H] = 1'b1;
        f[F_N] = 1'b1;
      end
      OP_DAA: begin
        r       = da_res;
        f[F_H]  = da_h;
        f[F_PV] = even_par(da_res);
        f[F_C]  = da_c;
      end
      default: wr_o = 1'b0;
    endcase
    if (op_i <= OP_DAA) begin
      f[F_Y] = (op_i == OP_CP) ? b_i[5] : r[5];
      f[F_X] = (op_i == OP_CP) ? b_i[3] : r[3];
      if (op_i != OP_CPL) begin
        f[F_S] = r[DW-1];
        f[F_Z] = (r == '0);
      end
    end
  end

  assign res_o   = r;
  assign flags_o = f;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
(
  input logic [3:0]    op_i,
  input logic [DW-1:0] a_i,
  input logic [DW-1:0] b_i,
  input logic [DW-1:0] flags_i,
  input logic [DW-1:0] res_o,
  input logic [DW-1:0] flags_o,
  input logic          wr_o
);
  always_comb begin
    if (op_i == OP_CP)
      assert_cp_no_write_R3: assert (!wr_o && flags_o[F_Y] == b_i[5] && flags_o[F_X] == b_i[3]);
    if (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR)
      assert_logic_flags_R4: assert (!flags_o[F_C] && !flags_o[F_N] && flags_o[F_PV] == ~^res_o);
    if (op_i == OP_INC || op_i == OP_DEC)
      assert_incdec_keep_c_R5: assert (flags_o[F_C] == flags_i[F_C]);
    if (op_i == OP_CPL)
      assert_cpl_R6: assert (res_o == ~a_i && flags_o[F_H] && flags_o[F_N]
                             && flags_o[F_S] == flags_i[F_S] && flags_o[F_C] == flags_i[F_C]);
    if (op_i > OP_DAA)
      assert_unused_op_R11: assert (!wr_o && res_o == a_i && flags_o == flags_i);
    if (op_i <= OP_DAA && op_i != OP_CPL)
      assert_zero_flag_R9: assert (flags_o[F_Z] == (res_o == '0) && flags_o[F_S] == res_o[DW-1]);
    if (op_i <= OP_DAA && op_i != OP_CP)
      assert_write_R12: assert (wr_o);
  end
endmodule

bind alu8_core alu8_core_chk u_chk (
  .op_i(op_i), .a_i(a_i), .b_i(b_i), .flags_i(flags_i),
  .res_o(res_o), .flags_o(flags_o), .wr_o(wr_o)
);

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] a = 8'd0, b = 8'd0, fi = 8'd0;
  logic [7:0] res, fo;
  logic       wr;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  alu8_core u_dut (
    .op_i(op), .a_i(a), .b_i(b), .flags_i(fi),
    .res_o(res), .flags_o(fo), .wr_o(wr)
  );

  function automatic logic par_even(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += v[i];
    return (n % 2) == 0;
  endfunction

  // returns {wr, res, flags}
  function automatic logic [16:0] model(input int o, input int x, input int y, input logic [7:0] f);
    int r, c, t;
    logic s, z, yb, h, xb, pv, n, cy, w;
    logic [7:0] rr;
    c = f[0]; s = 0; z = 0; h = f[4]; pv = f[2]; n = f[1]; cy = f[0]; w = 1; r = x;
    case (o)
      0, 1: begin
        if (o == 0) c = 0;
        t = x + y + c; r = t & 255;
        h = ((x & 15) + (y & 15) + c) > 15;
        pv = (x[7] == y[7]) && (r[7] != x[7]);
        cy = t > 255; n = 0;
      end
      2, 3, 4: begin
        if (o != 3) c = 0;
        t = x - y - c; r = t & 255;
        h = ((x & 15) - (y & 15) - c) < 0;
        pv = (x[7] != y[7]) && (r[7] != x[7]);
        cy = t < 0; n = 1; w = (o != 4);
      end
      5, 6, 7: begin
        r = (o == 5) ? (x & y) : (o == 6) ? (x | y) : (x ^ y);
        h = (o == 5); pv = par_even(8'(r)); n = 0; cy = 0;
      end
      8: begin r = (x + 1) & 255; h = (x & 15) == 15; pv = x == 127; n = 0; end
      9: begin r = (x + 255) & 255; h = (x & 15) == 0; pv = x == 128; n = 1; end
      10: begin r = 255 - x; h = 1; n = 1; end
      11: begin r = (256 - x) & 255; h = (x & 15) != 0; pv = x == 128; cy = x != 0; n = 1; end
      12: begin
        t = 0;
        if ((x & 15) > 9 || f[4]) t += 6;
        if (x > 153 || f[0]) begin t += 96; cy = 1; end
        r = f[1] ? ((x - t) & 255) : ((x + t) & 255);
        h = f[1] ? (f[4] && (x & 15) < 6) : ((x & 15) > 9);
        pv = par_even(8'(r));
      end
      default: w = 0;
    endcase
    rr = 8'(r);
    if (o > 12) return {1'b0, 8'(x), f};
    s = (o == 10) ? f[7] : rr[7];
    z = (o == 10) ? f[6] : (rr == 0);
    yb = (o == 4) ? y[5] : rr[5];
    xb = (o == 4) ? y[3] : rr[3];
    return {w, rr, s, z, yb, h, xb, pv, n, cy};
  endfunction

  function automatic string tag_of(input int o);
    case (o)
      0, 1: return "R1";  2, 3: return "R2";  4: return "R3";
      5, 6, 7: return "R4";  8, 9: return "R5";  10: return "R6";
      11: return "R7";  12: return "R8";  default: return "R11";
    endcase
  endfunction

  task automatic run(input int o, input int x, input int y, input logic [7:0] f, input string tag);
    logic [16:0] exp;
    @(posedge clk);
    op <= 4'(o); a <= 8'(x); b <= 8'(y); fi <= f;
    @(negedge clk);
    exp = model(o, x, y, f);
    checks++;
    if ({wr, res, fo} !== exp) begin
      fails++;
      $display("FAIL %s op=%0d a=%02h b=%02h f=%02h: got wr=%b res=%02h flags=%02h, exp wr=%b res=%02h flags=%02h",
               tag, o, x, y, f, wr, res, fo, exp[16], exp[15:8], exp[7:0]);
    end
  endtask

  // R10: b has no effect on single-operand ops
  task automatic b_ignored(input int o, input int x, input logic [7:0] f);
    logic [16:0] first;
    run(o, x, 8'h00, f, "R10");
    first = {wr, res, fo};
    run(o, x, 8'hFF, f, "R10");
    checks++;
    if ({wr, res, fo} !== first) begin
      fails++;
      $display("FAIL R10 op=%0d: got %05h expected %05h", o, {wr, res, fo}, first);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    rst_ni = 1'b1;
    run(0, 0, 0, 8'h00, "R9 zero result");
    run(0, 127, 1, 8'h00, "R1 overflow 7F+1");
    run(0, 8'h0F, 1, 8'h00, "R1 half carry");
    run(0, 200, 100, 8'h00, "R1 carry out");
    run(1, 8'hFF, 0, 8'h01, "R1 adc carry in");
    run(2, 50, 100, 8'h00, "R2 borrow");
    run(2, 8'h80, 1, 8'h00, "R2 overflow 80-1");
    run(3, 8'h10, 0, 8'h01, "R2 sbc nibble borrow");
    run(4, 8'h00, 8'h28, 8'h00, "R3 cp bits from b");
    run(4, 8'h28, 8'h28, 8'h00, "R3 cp equal");
    run(5, 8'h0F, 8'hFF, 8'h01, "R4 and parity");
    run(6, 8'h07, 8'h00, 8'h11, "R4 or odd parity");
    run(7, 8'hAA, 8'hAA, 8'h11, "R4 xor zero");
    run(8, 8'h7F, 0, 8'h01, "R5 inc overflow keep C");
    run(9, 8'h80, 0, 8'h00, "R5 dec overflow");
    run(9, 8'h01, 0, 8'h01, "R5 dec to zero");
    run(10, 8'h5A, 0, 8'hC5, "R6 cpl keeps flags");
    run(11, 8'h80, 0, 8'h00, "R7 neg 80");
    run(11, 8'h00, 0, 8'h00, "R7 neg zero");
    run(12, 8'h0A, 0, 8'h00, "R8 daa low fix");
    run(12, 8'h9A, 0, 8'h00, "R8 daa both");
    run(12, 8'h0F, 0, 8'h12, "R8 daa sub H");
    for (int fl = 0; fl < 8; fl++)
      for (int x = 0; x < 256; x += 17)
        run(12, x, 0, {3'b0, fl[2], 2'b0, fl[1], fl[0]}, "R8 daa sweep");
    run(13, 8'h33, 8'h44, 8'hA5, "R11 unused 13");
    run(15, 8'hF0, 8'h0F, 8'h5A, "R11 unused 15");
    run(6, 8'h00, 8'h00, 8'h00, "R12 write");
    for (int o = 8; o <= 12; o++) b_ignored(o, 8'h9C, 8'h13);
    for (int i = 0; i < 4000; i++) begin
      int o = $urandom_range(0, 15);
      run(o, $urandom_range(0, 255), $urandom_range(0, 255), 8'($urandom()), tag_of(o));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule